// File: doc/BRIEF.md
# Bayer defect pixel corrector

This block is a streaming filter for raw Bayer sensor data. It watches a stream of pixels and spots isolated bad pixels as they pass. A bad pixel is either a hot one, well above its neighbours, or a cold one, well below them. Each bad pixel it finds is replaced by the rounded mean of the two nearest pixels of the same colour in the same line. In a Bayer mosaic those two pixels sit two positions to the left and two to the right. There is no stored defect list, so the number of pixels it can correct has no limit.

Pixels arrive one per clock on `in_pix` while `in_valid` is high. `in_sol` is raised together with the first pixel of each line. The pixels of a line are expected on consecutive cycles. A cycle with `in_valid` low, or a new `in_sol`, breaks the horizontal neighbourhood. The output stream carries the same valid and line-start markers. It leaves the block after a fixed delay of NB_DIST+1 clocks, which is 3 with the defaults. `en` switches correction on or off, and `thresh` sets how far a pixel must stand out before it counts as a defect. 128 is the usual setting.

Top module: `bayer_defect_fix`

## Requirements
- R1: While `rst_n` is low, and on the first edges after it rises, `out_valid`, `out_sol` and `out_pix` are all zero.
- R2: `out_valid` and `out_sol` equal `in_valid` and `in_sol` from exactly 3 clocks earlier, so the latency is fixed.
- R3: A pixel counts as hot when its value exceeds each same-colour neighbour (positions x-2 and x+2) by strictly more than `thresh`. When correction applies, a hot pixel is replaced.
- R4: A pixel counts as cold when each same-colour neighbour exceeds its value by strictly more than `thresh`. When correction applies, a cold pixel is replaced.
- R5: The replacement value is (p[x-2] + p[x+2] + 1) >> 1. It is computed from the raw, uncorrected neighbour values.
- R6: These pixels leave unchanged: a pixel whose margin over either neighbour equals `thresh` exactly, and a pixel that lies between its two neighbours.
- R7: The first two and the last two pixels of a line are never corrected. A line ends where `in_valid` drops or the next `in_sol` arrives.
- R8: A neighbour counts only if every pixel from the centre to that neighbour arrived on consecutive valid cycles with no `in_sol` after the centre's own line start. A gap in `in_valid` blocks correction across it.
- R9: With `en` low, every pixel passes unchanged with the same latency. `en` and `thresh` are taken on the clock edge where the corrected pixel is registered, which is the edge that takes in its right-hand neighbour.
- R10: Any number of defects per line is corrected, including defects on adjacent pixels of different colours.
- R11: `out_pix` is zero in every cycle where `out_valid` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| en | input | 1 | Correction enable; low means pass-through |
| thresh | input | PIX_W | Detection margin, compared strictly |
| in_valid | input | 1 | Input pixel is present |
| in_sol | input | 1 | Input pixel is the first of a line |
| in_pix | input | PIX_W | Raw input pixel |
| out_valid | output | 1 | Output pixel is present |
| out_sol | output | 1 | Output pixel is the first of a line |
| out_pix | output | PIX_W | Corrected or passed pixel, zero when idle |

## Verification
The bound checker covers the rules that hold on every clock: marker latency, zero data while idle, and pass-through when disabled. It also checks that registered corrections equal the rounded neighbour mean, that line-start pixels are never touched, and that a pixel is never hot and cold at once. Other properties depend on a whole line's pattern: the strict threshold boundary, the last pixels of a line, gaps breaking the neighbourhood, and corrections counted per line against uncorrected neighbours. Only the bench's reference model shows these, driven by random lines with injected defects and by directed lines.

// File: rtl/dpc_pkg.sv
package dpc_pkg;

  // Wide enough for pixel widths up to 16 bits plus sum and threshold headroom.
  localparam int unsigned CALC_W = 18;
  typedef logic [CALC_W-1:0] calc_t;

  // Rounded mean of the two same-colour neighbours.
  function automatic calc_t pair_round_avg(calc_t a, calc_t b);
    return (a + b + calc_t'(1)) >> 1;
  endfunction

  // Centre stands above a neighbour by strictly more than the margin.
  function automatic logic stands_above(calc_t c, calc_t n, calc_t t);
    return c > (n + t);
  endfunction

  // Centre sits below a neighbour by strictly more than the margin.
  function automatic logic stands_below(calc_t c, calc_t n, calc_t t);
    return (c + t) < n;
  endfunction

endpackage

// File: rtl/dpc_window.sv
// Horizontal pixel window: a shift line of 2*NB_DIST stages plus the live
// input. Exposes the centre, its two same-colour neighbours and whether each
// neighbour belongs to the same unbroken run of the centre's line.
module dpc_window #(
  parameter int unsigned PIX_W   = 10,
  parameter int unsigned NB_DIST = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic             in_sol,
  input  logic [PIX_W-1:0] in_pix,
  output logic             ctr_valid,
  output logic             ctr_sol,
  output logic [PIX_W-1:0] ctr_pix,
  output logic [PIX_W-1:0] left_pix,
  output logic [PIX_W-1:0] right_pix,
  output logic             left_ok,
  output logic             right_ok
);

  localparam int unsigned SPAN = 2 * NB_DIST;

  // Index 0 is the live input, index k the value taken in k edges ago.
  logic             vld_w [SPAN+1];
  logic             sol_w [SPAN];
  logic [PIX_W-1:0] pix_w [SPAN+1];

  assign vld_w[0] = in_valid;
  assign sol_w[0] = in_sol;
  assign pix_w[0] = in_pix;

  genvar k;
  generate
    for (k = 1; k <= SPAN; k++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          vld_w[k] <= 1'b0;
          pix_w[k] <= '0;
        end else begin
          vld_w[k] <= vld_w[k-1];
          pix_w[k] <= pix_w[k-1];
        end
      end
      // The line-start flag of the oldest stage is never consulted.
      if (k < SPAN) begin : g_sol
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) sol_w[k] <= 1'b0;
          else        sol_w[k] <= sol_w[k-1];
        end
      end
    end
  endgenerate

  assign ctr_valid = vld_w[NB_DIST];
  assign ctr_sol   = sol_w[NB_DIST];
  assign ctr_pix   = pix_w[NB_DIST];
  assign left_pix  = pix_w[SPAN];
  assign right_pix = pix_w[0];

  // Left side: centre back to the older neighbour all valid, and no line
  // start on the centre or between it and that neighbour.
  always_comb begin
    left_ok = 1'b1;
    for (int i = NB_DIST; i <= SPAN; i++) begin
      left_ok = left_ok & vld_w[i];
    end
    for (int i = NB_DIST; i < SPAN; i++) begin
      left_ok = left_ok & ~sol_w[i];
    end
  end

  // Right side: centre up to the newer neighbour all valid, and no new line
  // start after the centre.
  always_comb begin
    right_ok = 1'b1;
    for (int i = 0; i <= NB_DIST; i++) begin
      right_ok = right_ok & vld_w[i];
    end
    for (int i = 0; i < NB_DIST; i++) begin
      right_ok = right_ok & ~sol_w[i];
    end
  end

endmodule

// File: rtl/dpc_detect.sv
// Pure combinational defect test and replacement value.
module dpc_detect #(
  parameter int unsigned PIX_W = 10
) (
  input  logic [PIX_W-1:0] ctr_pix,
  input  logic [PIX_W-1:0] left_pix,
  input  logic [PIX_W-1:0] right_pix,
  input  logic [PIX_W-1:0] thresh,
  output logic             is_hot,
  output logic             is_cold,
  output logic [PIX_W-1:0] fix_pix
);

  import dpc_pkg::*;

  calc_t c_w, l_w, r_w, t_w;

  assign c_w = calc_t'(ctr_pix);
  assign l_w = calc_t'(left_pix);
  assign r_w = calc_t'(right_pix);
  assign t_w = calc_t'(thresh);

  assign is_hot  = stands_above(c_w, l_w, t_w) & stands_above(c_w, r_w, t_w);
  assign is_cold = stands_below(c_w, l_w, t_w) & stands_below(c_w, r_w, t_w);
  assign fix_pix = PIX_W'(pair_round_avg(l_w, r_w));

endmodule

// File: rtl/dpc_outreg.sv
// Output register: picks the replacement or the raw centre and zeroes idle data.
module dpc_outreg #(
  parameter int unsigned PIX_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctr_valid,
  input  logic             ctr_sol,
  input  logic [PIX_W-1:0] ctr_pix,
  input  logic [PIX_W-1:0] fix_pix,
  input  logic             apply_fix,
  output logic             out_valid,
  output logic             out_sol,
  output logic [PIX_W-1:0] out_pix
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_sol   <= 1'b0;
      out_pix   <= '0;
    end else begin
      out_valid <= ctr_valid;
      out_sol   <= ctr_valid & ctr_sol;
      if (!ctr_valid)     out_pix <= '0;
      else if (apply_fix) out_pix <= fix_pix;
      else                out_pix <= ctr_pix;
    end
  end

endmodule

// File: rtl/bayer_defect_fix.sv
// Streaming Bayer defect corrector, latency NB_DIST+1 clocks.
module bayer_defect_fix #(
  parameter int unsigned PIX_W   = 10,
  parameter int unsigned NB_DIST = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [PIX_W-1:0] thresh,
  input  logic             in_valid,
  input  logic             in_sol,
  input  logic [PIX_W-1:0] in_pix,
  output logic             out_valid,
  output logic             out_sol,
  output logic [PIX_W-1:0] out_pix
);

  logic             ctr_valid, ctr_sol;
  logic [PIX_W-1:0] ctr_pix, left_pix, right_pix, fix_pix;
  logic             left_ok, right_ok;

  // Named internal events, visible to the bound checker.
  logic             ev_hot, ev_cold, ev_fix;

  dpc_window #(.PIX_W(PIX_W), .NB_DIST(NB_DIST)) u_window (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_sol    (in_sol),
    .in_pix    (in_pix),
    .ctr_valid (ctr_valid),
    .ctr_sol   (ctr_sol),
    .ctr_pix   (ctr_pix),
    .left_pix  (left_pix),
    .right_pix (right_pix),
    .left_ok   (left_ok),
    .right_ok  (right_ok)
  );

  dpc_detect #(.PIX_W(PIX_W)) u_detect (
    .ctr_pix   (ctr_pix),
    .left_pix  (left_pix),
    .right_pix (right_pix),
    .thresh    (thresh),
    .is_hot    (ev_hot),
    .is_cold   (ev_cold),
    .fix_pix   (fix_pix)
  );

  assign ev_fix = en & ctr_valid & left_ok & right_ok & (ev_hot | ev_cold);

  dpc_outreg #(.PIX_W(PIX_W)) u_outreg (
    .clk       (clk),
    .rst_n     (rst_n),
    .ctr_valid (ctr_valid),
    .ctr_sol   (ctr_sol),
    .ctr_pix   (ctr_pix),
    .fix_pix   (fix_pix),
    .apply_fix (ev_fix),
    .out_valid (out_valid),
    .out_sol   (out_sol),
    .out_pix   (out_pix)
  );

endmodule

// File: rtl/bayer_defect_fix_chk.sv
// Protocol and arithmetic checker, bound into the top module.
module bayer_defect_fix_chk #(
  parameter int unsigned PIX_W = 10
) (
  input logic             clk,
  input logic             rst_n,
  input logic             en,
  input logic             in_valid,
  input logic             in_sol,
  input logic [PIX_W-1:0] in_pix,
  input logic             out_valid,
  input logic             out_sol,
  input logic [PIX_W-1:0] out_pix,
  input logic             ev_hot,
  input logic             ev_cold,
  input logic             ev_fix
);

  // Edges seen since reset release, saturating, so $past never reaches reset.
  logic [2:0] age;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         age <= '0;
    else if (age != 7)  age <= age + 3'd1;
  end

  function automatic logic [PIX_W-1:0] rmean(logic [PIX_W-1:0] a, logic [PIX_W-1:0] b);
    logic [PIX_W:0] s;
    s = {1'b0, a} + {1'b0, b} + {{PIX_W{1'b0}}, 1'b1};
    return s[PIX_W:1];
  endfunction

  p_valid_delay_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (age >= 3) |-> (out_valid == $past(in_valid, 3)));

  p_sol_delay_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (age >= 3) |-> (out_sol == ($past(in_sol, 3) & $past(in_valid, 3))));

  p_idle_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> (out_pix == '0));

  p_bypass_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (age >= 3 && out_valid && !$past(en)) |-> (out_pix == $past(in_pix, 3)));

  p_fix_value_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (age >= 5 && $past(ev_fix)) |-> (out_pix == rmean($past(in_pix, 1), $past(in_pix, 5))));

  p_no_fix_pass_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (age >= 3 && out_valid && !$past(ev_fix)) |-> (out_pix == $past(in_pix, 3)));

  p_line_head_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (age >= 3 && out_valid && out_sol) |-> (out_pix == $past(in_pix, 3)));

  p_hot_cold_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(ev_hot && ev_cold));

endmodule

bind bayer_defect_fix bayer_defect_fix_chk #(.PIX_W(PIX_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .en        (en),
  .in_valid  (in_valid),
  .in_sol    (in_sol),
  .in_pix    (in_pix),
  .out_valid (out_valid),
  .out_sol   (out_sol),
  .out_pix   (out_pix),
  .ev_hot    (ev_hot),
  .ev_cold   (ev_cold),
  .ev_fix    (ev_fix)
);

// File: tb/bayer_defect_fix_tb_top.sv
module bayer_defect_fix_tb_top;

  localparam int PW   = 10;
  localparam int MAXV = (1 << PW) - 1;
  localparam int NCYC = 16384;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          en;
  logic [PW-1:0] thresh;
  logic          in_valid, in_sol;
  logic [PW-1:0] in_pix;
  logic          out_valid, out_sol;
  logic [PW-1:0] out_pix;

  always #4 clk = ~clk;

  bayer_defect_fix #(.PIX_W(PW), .NB_DIST(2)) dut_i (
    .clk(clk), .rst_n(rst_n), .en(en), .thresh(thresh),
    .in_valid(in_valid), .in_sol(in_sol), .in_pix(in_pix),
    .out_valid(out_valid), .out_sol(out_sol), .out_pix(out_pix)
  );

  // Per-cycle record of what was driven.
  int    rv [NCYC];
  int    rs [NCYC];
  int    rp [NCYC];
  int    ren[NCYC];
  int    rth[NCYC];
  int    n = 0;
  int    checks = 0;
  int    errors = 0;
  bit    done = 1'b0;
  int    line_buf[64];
  string note = "";

  task automatic chk(string tag, int got, int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d (cycle %0d)", tag, got, exp, n);
    end
  endtask

  // Reference model: centre at cycle m, decision taken at cycle k.
  function automatic void model(input int m, input int k,
                                output int ev, output int es, output int ep,
                                output string tag);
    int c, l, r, t;
    bit lok, rok, hot, cold;
    ev = 0; es = 0; ep = 0; tag = "R11";
    if (m < 0) return;
    if (rv[m] == 0) return;
    ev = 1; es = rs[m]; ep = rp[m];
    if (ren[k] == 0) begin tag = "R9"; return; end
    lok = (m >= 2) && rv[m-2] != 0 && rv[m-1] != 0 && rs[m] == 0 && rs[m-1] == 0;
    rok = rv[m+1] != 0 && rv[m+2] != 0 && rs[m+1] == 0 && rs[m+2] == 0;
    if (!(lok && rok)) begin tag = "R7 R8"; return; end
    c = rp[m]; l = rp[m-2]; r = rp[m+2]; t = rth[k];
    hot  = (c - l > t) && (c - r > t);
    cold = (l - c > t) && (r - c > t);
    if (hot)       begin ep = (l + r + 1) / 2; tag = "R3 R5"; end
    else if (cold) begin ep = (l + r + 1) / 2; tag = "R4 R5"; end
    else           tag = "R6";
  endfunction

  task automatic cyc(bit v, bit s, int p, bit e, int t);
    int ev, es, ep;
    string tag;
    in_valid = v;
    in_sol   = s;
    in_pix   = p[PW-1:0];
    en       = e;
    thresh   = t[PW-1:0];
    rv[n] = v; rs[n] = s; rp[n] = p; ren[n] = e; rth[n] = t;
    @(posedge clk);
    @(negedge clk);
    model(n - 2, n, ev, es, ep, tag);
    chk("R2 out_valid", int'(out_valid), ev);
    chk("R2 out_sol", int'(out_sol), es);
    chk({tag, " out_pix ", note}, int'(out_pix), ep);
    n++;
  endtask

  task automatic idle(int k);
    for (int i = 0; i < k; i++) cyc(1'b0, 1'b0, int'($urandom % 1024), 1'b1, 128);
  endtask

  // Sends line_buf[0..len-1]; a gap cycle is inserted before pixel gap_at.
  task automatic send_line(int len, bit e, int t, int gap_at);
    for (int x = 0; x < len; x++) begin
      if (x == gap_at) cyc(1'b0, 1'b0, int'($urandom % 1024), e, t);
      cyc(1'b1, x == 0, line_buf[x], e, t);
    end
  endtask

  task automatic flat_line(int len, int base);
    for (int x = 0; x < len; x++) line_buf[x] = base;
  endtask

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0; en = 1'b1; thresh = 10'd128;
    in_valid = 1'b0; in_sol = 1'b0; in_pix = '0;
    repeat (3) @(negedge clk);
    // R1: outputs cleared under reset
    chk("R1 out_valid", int'(out_valid), 0);
    chk("R1 out_sol", int'(out_sol), 0);
    chk("R1 out_pix", int'(out_pix), 0);
    rst_n = 1'b1;
    idle(3);

    // R6 / R3 / R4: strict margin boundary with thresh 100
    note = "margin";
    flat_line(16, 200);
    line_buf[4]  = 300;  // equal margin, kept (R6)
    line_buf[8]  = 301;  // hot, fixed (R3)
    line_buf[10] = 99;   // cold, fixed (R4)
    line_buf[12] = 350; line_buf[14] = 500; // between neighbours, kept (R6)
    send_line(16, 1'b1, 100, -1);
    idle(2);

    // R5: rounding of an odd neighbour sum
    note = "rounding";
    flat_line(10, 0);
    line_buf[2] = 200; line_buf[4] = 900; line_buf[6] = 201;
    send_line(10, 1'b1, 128, -1);
    idle(1);

    // R7: defects on the first two and last two pixels of a line
    note = "line edges";
    flat_line(8, 500);
    line_buf[0] = 1000; line_buf[1] = 0; line_buf[6] = 1000; line_buf[7] = 3;
    send_line(8, 1'b1, 128, -1);
    // back-to-back next line, so the next in_sol ends the previous one
    flat_line(6, 100);
    line_buf[0] = 900; line_buf[5] = 900;
    send_line(6, 1'b1, 128, -1);
    idle(2);

    // R8: a valid gap between a defect and its right neighbour
    note = "gap";
    flat_line(12, 300);
    line_buf[5] = 1000; line_buf[8] = 1000;
    send_line(12, 1'b1, 128, 6);
    idle(2);

    // R9: defects with correction disabled
    note = "bypass";
    flat_line(12, 300);
    line_buf[4] = 1000; line_buf[7] = 0;
    send_line(12, 1'b0, 128, -1);
    idle(1);

    // R10: many defects, adjacent ones of different colour
    note = "R10 many";
    flat_line(20, 400);
    line_buf[4] = 1000; line_buf[5] = 10; line_buf[9] = 1020;
    line_buf[12] = 0; line_buf[13] = 900; line_buf[16] = 1023;
    send_line(20, 1'b1, 128, -1);
    idle(3);

    // Random lines with injected defects.
    note = "random";
    while (n < 12000) begin
      int len, t, b0, b1, gap_at;
      bit e;
      len = 1 + int'($urandom % 30);
      case ($urandom % 4)
        0: t = 128;
        1: t = 0;
        2: t = 40;
        default: t = 1023;
      endcase
      b0 = int'($urandom % 1024);
      b1 = int'($urandom % 1024);
      for (int x = 0; x < len; x++) begin
        int v;
        v = ((x % 2) != 0 ? b1 : b0) + int'($urandom % 17) - 8;
        if (v < 0) v = 0;
        if (v > MAXV) v = MAXV;
        if ($urandom % 6 == 0) v = int'($urandom % 1024);
        line_buf[x] = v;
      end
      e = ($urandom % 8) != 0;
      gap_at = ($urandom % 8 == 0) ? int'($urandom % len) : -1;
      send_line(len, e, t, gap_at);
      idle(int'($urandom % 3));
    end
    idle(4);

    done = 1'b1;
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog (R2 stream progress): got hang expected completion");
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule